// File: doc/BRIEF.md
# Deferred Fetch-Fault Pipeline Tracker

This block follows instructions through a short in-order pipeline that has a fetch stage, a decode stage and an execute stage. It records fetch-time faults against each instruction without acting on them at once. Two things tag an instruction. One is a fetch whose memory access returns an error. The other is a fetched word that the decoder flags as a breakpoint. The tag travels with the instruction's PC until the instruction is in execute.

An exception request is raised only when the tagged instruction actually executes. That means it is valid in execute, the pipeline is not stalled, and its condition check passes. A tagged instruction removed by a taken-branch flush produces no request, and neither does one whose condition fails. The tag is simply dropped.

Breakpoints use the same deferred path as fetch errors and are reported on their own request line. When a request fires, every younger instruction is discarded. The faulting PC is then presented on a register that holds until the next request. Real instruction decode is not part of this block.

Top module: `fault_defer_pipe`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `pabt_req` and `brk_req` are 0 and `fault_pc` is 0.
- R2: A fetch with `fetch_valid`=1 and `fetch_err`=1 raises no request at fetch. With no stall, flush or condition failure, `pabt_req` is high in the cycle following the third rising edge after the edge that sampled the fetch, and at no earlier cycle.
- R3: A flush is `flush`=1 sampled with `stall`=0. It discards the instructions in fetch and decode and the fetch offered in the same cycle, so none of them ever raises a request.
- R4: A tagged instruction in execute with `cond_pass`=0 leaves without raising any request, and its tag is lost.
- R5: A valid fetch with `fetch_brk`=1 and `fetch_err`=0 raises `brk_req` under exactly the deferred rules of R2 to R4. When both flags are 1, the fetch is treated as an error and raises `pabt_req`.
- R6: While `stall`=1, every stage register holds its entry and tag, no request is raised, and `flush` and `cond_pass` are ignored.
- R7: Each request is high for a single cycle. The edge that fires it discards every younger instruction, including the fetch offered in that cycle.
- R8: `fault_pc` takes the PC of the instruction that fired, in the same cycle as its request. It keeps that value until the next request.
- R9: `pabt_req` and `brk_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fetch_valid | input | 1 | An instruction is offered by fetch this cycle |
| fetch_err | input | 1 | The instruction memory flagged an error on this fetch |
| fetch_brk | input | 1 | The fetched word is a breakpoint instruction |
| fetch_pc | input | PC_W | PC of the fetched instruction |
| stall | input | 1 | Freeze every stage this cycle |
| flush | input | 1 | Taken branch in execute; discard younger instructions |
| cond_pass | input | 1 | Condition check of the instruction in execute passed |
| pabt_req | output | 1 | Prefetch-abort request pulse, registered |
| brk_req | output | 1 | Breakpoint request pulse, registered |
| fault_pc | output | PC_W | PC of the instruction that raised the latest request |

## Verification
The assertions take for granted that every input is at a known level on each clock edge. They also assume that reset is held for at least one edge before normal operation. Any mix of `stall`, `flush` and `cond_pass` is legal, because stall takes precedence and a flush during a stall is defined to do nothing.

The random stimulus draws every control input independently, at rates that often put stalls, flushes and failed conditions on a tagged instruction. Directed cases place a flush, a failed condition and a long stall exactly on a tagged instruction. They also cover two faults back to back and a fetch that is both an error and a breakpoint.

// File: rtl/fdp_pkg.sv
package fdp_pkg;

  // Fault tag carried by each pipeline entry. An error outranks a breakpoint.
  typedef enum logic [1:0] {
    TAG_NONE  = 2'd0,
    TAG_ABORT = 2'd1,
    TAG_BRK   = 2'd2
  } tag_e;

  localparam int TAG_W = 2;

  // Entry layout: {valid, tag, pc}
  function automatic int ent_width(input int pc_w);
    return pc_w + TAG_W + 1;
  endfunction

endpackage

// File: rtl/fdp_fetch_tag.sv
module fdp_fetch_tag
  import fdp_pkg::*;
#(
  parameter int PC_W  = 32,
  localparam int ENT_W = PC_W + TAG_W + 1
) (
  input  logic            fetch_valid,
  input  logic            fetch_err,
  input  logic            fetch_brk,
  input  logic [PC_W-1:0] fetch_pc,
  output logic [ENT_W-1:0] ent
);

  tag_e tag;

  always_comb begin
    tag = TAG_NONE;
    if (fetch_valid) begin
      if (fetch_err)      tag = TAG_ABORT;
      else if (fetch_brk) tag = TAG_BRK;
    end
    ent = {fetch_valid, tag, fetch_pc};
  end

endmodule

// File: rtl/fdp_stage.sv
module fdp_stage #(
  parameter int ENT_W = 35
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             kill,
  input  logic [ENT_W-1:0] d,
  output logic [ENT_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (!hold) q <= kill ? '0 : d;
  end

endmodule

// File: rtl/fdp_exec.sv
module fdp_exec
  import fdp_pkg::*;
#(
  parameter int PC_W  = 32,
  localparam int ENT_W = PC_W + TAG_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stall,
  input  logic             cond_pass,
  input  logic [ENT_W-1:0] ex_ent,
  output logic             fire,
  output logic             pabt_req,
  output logic             brk_req,
  output logic [PC_W-1:0]  fault_pc
);

  logic            ex_valid;
  tag_e            ex_tag;
  logic [PC_W-1:0] ex_pc;

  assign ex_valid = ex_ent[ENT_W-1];
  assign ex_tag   = tag_e'(ex_ent[PC_W +: TAG_W]);
  assign ex_pc    = ex_ent[PC_W-1:0];

  // The instruction executes only when it is valid, not stalled and its
  // condition passes; only then does a fault tag turn into a request.
  assign fire = !stall && ex_valid && cond_pass && (ex_tag != TAG_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      pabt_req <= 1'b0;
      brk_req  <= 1'b0;
      fault_pc <= '0;
    end else begin
      pabt_req <= fire && (ex_tag == TAG_ABORT);
      brk_req  <= fire && (ex_tag == TAG_BRK);
      if (fire) fault_pc <= ex_pc;
    end
  end

endmodule

// File: rtl/fault_defer_pipe.sv
module fault_defer_pipe
  import fdp_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int DEPTH = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fetch_valid,
  input  logic            fetch_err,
  input  logic            fetch_brk,
  input  logic [PC_W-1:0] fetch_pc,
  input  logic            stall,
  input  logic            flush,
  input  logic            cond_pass,
  output logic            pabt_req,
  output logic            brk_req,
  output logic [PC_W-1:0] fault_pc
);

  localparam int ENT_W = PC_W + TAG_W + 1;
  localparam int LAST  = DEPTH - 1;

  logic [ENT_W-1:0] fetch_ent;
  logic [ENT_W-1:0] st_in [DEPTH];
  logic [ENT_W-1:0] st_q  [DEPTH];
  logic             fire;
  logic             kill;

  fdp_fetch_tag #(.PC_W(PC_W)) u_tag (
    .fetch_valid (fetch_valid),
    .fetch_err   (fetch_err),
    .fetch_brk   (fetch_brk),
    .fetch_pc    (fetch_pc),
    .ent         (fetch_ent)
  );

  // A taken branch or a firing fault discards everything younger than execute.
  assign kill = !stall && (flush || fire);

  assign st_in[0] = fetch_ent;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i > 0) begin : g_link
      assign st_in[i] = st_q[i-1];
    end
    fdp_stage #(.ENT_W(ENT_W)) u_stage (
      .clk  (clk),
      .rst  (rst),
      .hold (stall),
      .kill (kill),
      .d    (st_in[i]),
      .q    (st_q[i])
    );
  end

  fdp_exec #(.PC_W(PC_W)) u_exec (
    .clk       (clk),
    .rst       (rst),
    .stall     (stall),
    .cond_pass (cond_pass),
    .ex_ent    (st_q[LAST]),
    .fire      (fire),
    .pabt_req  (pabt_req),
    .brk_req   (brk_req),
    .fault_pc  (fault_pc)
  );

endmodule

// File: rtl/fault_defer_chk.sv
module fault_defer_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            stall,
  input logic            flush,
  input logic            pabt_req,
  input logic            brk_req,
  input logic [PC_W-1:0] fault_pc
);

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!pabt_req && !brk_req && fault_pc == '0)); // R1

  AST_FLUSH_DROPS: assert property (@(posedge clk) disable iff (rst)
    (flush && !stall) |=> ##1 (!pabt_req && !brk_req)); // R3

  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (rst)
    stall |=> (!pabt_req && !brk_req)); // R6

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    (pabt_req || brk_req) |=> (!pabt_req && !brk_req)); // R7

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!pabt_req && !brk_req) |-> $stable(fault_pc)); // R8

  AST_ONE_KIND: assert property (@(posedge clk) disable iff (rst)
    !(pabt_req && brk_req)); // R9

endmodule

bind fault_defer_pipe fault_defer_chk #(.PC_W(PC_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .stall    (stall),
  .flush    (flush),
  .pabt_req (pabt_req),
  .brk_req  (brk_req),
  .fault_pc (fault_pc)
);

// File: tb/fault_defer_pipe_test.sv
module fault_defer_pipe_test;

  localparam int PC_W = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            fetch_valid = 1'b0, fetch_err = 1'b0, fetch_brk = 1'b0;
  logic [PC_W-1:0] fetch_pc = '0;
  logic            stall = 1'b0, flush = 1'b0, cond_pass = 1'b1;
  logic            pabt_req, brk_req;
  logic [PC_W-1:0] fault_pc;

  int checks = 0;
  int errors = 0;

  // Bench model: per-stage valid, tag (0 none, 1 error, 2 breakpoint), pc
  bit        mv [3];
  int        mt [3];
  bit [31:0] mp [3];
  bit        e_abt = 0, e_brk = 0;
  bit [31:0] e_pc = 0;

  always #2.5 clk = ~clk;

  fault_defer_pipe #(.PC_W(PC_W), .DEPTH(3)) uut (
    .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_err(fetch_err),
    .fetch_brk(fetch_brk), .fetch_pc(fetch_pc), .stall(stall), .flush(flush),
    .cond_pass(cond_pass), .pabt_req(pabt_req), .brk_req(brk_req),
    .fault_pc(fault_pc)
  );

  task automatic check1(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int tag_of(bit v, bit e, bit b);
    if (!v) return 0;
    if (e)  return 1;   // R5: error outranks breakpoint
    if (b)  return 2;
    return 0;
  endfunction

  // Model one rising edge from the inputs applied before it.
  task automatic model_edge();
    bit fire, kill;
    if (stall) begin            // R6: hold everything, no request
      e_abt = 0; e_brk = 0;
      return;
    end
    fire  = mv[2] && cond_pass && (mt[2] != 0);
    e_abt = fire && (mt[2] == 1);
    e_brk = fire && (mt[2] == 2);
    if (fire) e_pc = mp[2];
    kill  = flush || fire;
    mv[2] = kill ? 0 : mv[1]; mt[2] = kill ? 0 : mt[1]; mp[2] = mp[1];
    mv[1] = kill ? 0 : mv[0]; mt[1] = kill ? 0 : mt[0]; mp[1] = mp[0];
    mv[0] = kill ? 0 : fetch_valid;
    mt[0] = kill ? 0 : tag_of(fetch_valid, fetch_err, fetch_brk);
    mp[0] = fetch_pc;
  endtask

  // Apply inputs at the falling edge, cross one rising edge, compare at the next falling edge.
  task automatic step(string req, bit v, bit e, bit b, bit [31:0] pc,
                      bit s, bit f, bit c);
    fetch_valid = v; fetch_err = e; fetch_brk = b; fetch_pc = pc;
    stall = s; flush = f; cond_pass = c;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check1(req, "pabt_req", 32'(pabt_req), 32'(e_abt));
    check1(req, "brk_req",  32'(brk_req),  32'(e_brk));
    check1("R8", "fault_pc", fault_pc, e_pc);
    check1("R9", "both requests", 32'(pabt_req && brk_req), 32'd0);
  endtask

  task automatic idle(string req, int n, bit c);
    for (int i = 0; i < n; i++) step(req, 0, 0, 0, 32'h0, 0, 0, c);
  endtask

  initial begin
    #900000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) begin mv[i] = 0; mt[i] = 0; mp[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check1("R1", "pabt_req at reset", 32'(pabt_req), 32'd0);
    check1("R1", "brk_req at reset", 32'(brk_req), 32'd0);
    check1("R1", "fault_pc at reset", fault_pc, 32'd0);
    rst = 1'b0;
    idle("R1", 1, 1);

    // R2: error tag surfaces exactly three edges later
    step("R2", 1, 1, 0, 32'h100, 0, 0, 1);
    idle("R2", 2, 1);
    check1("R2", "no early abort", 32'(pabt_req), 32'd0);
    idle("R2", 1, 1);
    check1("R2", "abort at execute", 32'(pabt_req), 32'd1);
    check1("R8", "faulting pc", fault_pc, 32'h100);
    idle("R7", 3, 1);

    // R5: breakpoint, then error+breakpoint together
    step("R5", 1, 0, 1, 32'h200, 0, 0, 1);
    idle("R5", 4, 1);
    step("R5", 1, 1, 1, 32'h204, 0, 0, 1);
    idle("R5", 4, 1);

    // R3: flush while the tagged instruction sits in decode, and fetch offered in the flush cycle
    step("R3", 1, 1, 0, 32'h300, 0, 0, 1);
    step("R3", 1, 0, 1, 32'h304, 0, 0, 1);
    step("R3", 1, 1, 0, 32'h308, 0, 1, 1);
    idle("R3", 5, 1);

    // R4: condition fails in execute
    step("R4", 1, 1, 0, 32'h400, 0, 0, 0);
    idle("R4", 6, 0);
    idle("R4", 2, 1);

    // R6: tagged instruction held in execute under stall with flush and cond_pass active
    step("R6", 1, 0, 1, 32'h500, 0, 0, 1);
    idle("R6", 2, 1);
    for (int i = 0; i < 5; i++) step("R6", 1, 1, 0, 32'h5F0, 1, 1, 1);
    idle("R6", 3, 1);

    // R7: back-to-back tagged instructions; only the older one fires
    step("R7", 1, 1, 0, 32'h600, 0, 0, 1);
    step("R7", 1, 0, 1, 32'h604, 0, 0, 1);
    step("R7", 1, 1, 0, 32'h608, 0, 0, 1);
    idle("R7", 6, 1);

    // Constrained random mix
    void'($urandom(32'h0F1E_2D3C));
    for (int n = 0; n < 4000; n++) begin
      bit v, e, b, s, f, c;
      v = ($urandom % 100) < 80;
      e = ($urandom % 100) < 12;
      b = ($urandom % 100) < 12;
      s = ($urandom % 100) < 15;
      f = ($urandom % 100) < 6;
      c = ($urandom % 100) < 80;
      step("R2", v, e, b, $urandom, s, f, c);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule